// File: doc/BRIEF.md
# Sample-Phase Tuning Sweep Sequencer

This block runs the receive sample-phase tuning procedure of a card host controller. When it is started, it makes a fixed number of trials. Each trial first writes the maximum value into the data timeout register. It then asks the timing programmer to apply a trial phase and asks the tuning-command engine to run one tuning command. The pass/fail answer is stored in a per-phase result mask. The trial phase is the trial number modulo the phase count. Because there are more trials than phases, the lowest phases are tested a second time, and the later answer replaces the earlier one.

After the last trial, the sequencer hands the mask to a window finder and waits for its answer. If the finder reports that no phase passed, the sequence ends with the error flag set, and the timing is left as it is. Otherwise the chosen phase is applied through the timing programmer, with the bus mode currently selected. Every exchange with the three neighbours is a request held high until an acknowledge.

States: `ST_IDLE` (waiting for start), `ST_TMO` (timeout write), `ST_SET` (trial phase request), `ST_TUNE` (tuning command request), `ST_FIND` (finder request), `ST_APPLY` (final phase request). Transitions:
- IDLE→TMO on start.
- TMO→SET always.
- SET→TUNE on timing acknowledge.
- TUNE→TMO on command acknowledge when trials remain.
- TUNE→FIND on command acknowledge after the last trial.
- FIND→APPLY on finder acknowledge with a usable phase.
- FIND→IDLE on finder acknowledge with all-fail.
- APPLY→IDLE on timing acknowledge.

Top module: `phase_tune_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, done, error, all request outputs and the timeout write are low, and the mask reads zero.
- R2: One sweep makes exactly STEPS (default 40) trial timing requests, with `tim_final_o` low. Trial n carries phase n modulo PHASES (default 32).
- R3: Exactly one timeout write, with `tmo_data_o` all ones, happens in the cycle just before each trial timing request.
- R4: A passing command answer (`cmd_pass_i`=1 with acknowledge) sets mask bit equal to the trial phase, and a failing one clears it. A retest of a phase overwrites the earlier result.
- R5: The mask is cleared to zero when a sweep starts.
- R6: Each request stays high, with stable phase, until the cycle in which its acknowledge is sampled. The sequencer does not advance without the acknowledge.
- R7: After the last command answer, the finder is requested, and `mask_o` then holds the final sweep result.
- R8: If the finder acknowledges with `fnd_allfail_i`=1, the sequence ends with `err_o`=1 and a one-cycle `done_o`, and no final timing request is made.
- R9: Otherwise one final timing request is made with `tim_final_o`=1, phase `fnd_phase_i` and mode equal to `bus_mode_i`. Then `done_o` pulses with `err_o`=0.
- R10: A start pulse while the sequencer is busy is ignored.
- R11: At most one of the timeout write, timing request, command request and finder request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (ignored while busy) |
| bus_mode_i | input | MODE_W | Current bus timing mode |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence found no passing phase |
| mask_o | output | PHASES | Per-phase pass mask |
| tmo_wr_o | output | 1 | Data timeout register write strobe |
| tmo_data_o | output | TMO_W | Data timeout write value (all ones) |
| tim_req_o | output | 1 | Timing programmer request |
| tim_final_o | output | 1 | Request carries the chosen final phase |
| tim_phase_o | output | PH_W | Phase to apply |
| tim_mode_o | output | MODE_W | Bus mode to apply |
| tim_ack_i | input | 1 | Timing programmer acknowledge |
| cmd_req_o | output | 1 | Tuning command request |
| cmd_ack_i | input | 1 | Tuning command acknowledge |
| cmd_pass_i | input | 1 | Tuning command passed (valid with acknowledge) |
| fnd_req_o | output | 1 | Window finder request |
| fnd_ack_i | input | 1 | Window finder acknowledge |
| fnd_allfail_i | input | 1 | Finder saw no passing phase |
| fnd_phase_i | input | PH_W | Finder's chosen phase |

## Verification
The bench targets the eight retested phases. It uses a pass pattern where phases that passed on first trial fail on retest, and another where only the retests pass. A design that kept the first result, or wrapped at the wrong count, would leave the wrong mask and hand it to the finder. An all-fail sweep checks that no final phase is applied. A design that applied the finder's phase anyway would show a final timing request. A start pulse injected mid-sweep would otherwise restart the count and produce extra trials and timeout writes. Acknowledge latencies are varied, so that a design advancing early would show wrong phase order or missing timeout writes.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TMO,
        ST_SET,
        ST_TUNE,
        ST_FIND,
        ST_APPLY
    } tune_state_t;
endpackage

// File: rtl/phase_tune_step_ctr.sv
module phase_tune_step_ctr #(
    parameter int STEPS  = 40,
    localparam int CNT_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] step,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   step <= '0;
        else if (clr) step <= '0;
        else if (inc) step <= step + 1'b1;
    end

    assign last = (step == CNT_W'(STEPS - 1));
endmodule

// File: rtl/phase_tune_mask.sv
module phase_tune_mask #(
    parameter int PHASES = 32,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PH_W-1:0]   wr_idx,
    input  logic              wr_val,
    output logic [PHASES-1:0] mask
);
    for (genvar b = 0; b < PHASES; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask[b] <= 1'b0;
            else if (clr)
                mask[b] <= 1'b0;
            else if (wr_en && wr_idx == PH_W'(b))
                mask[b] <= wr_val;
        end
    end
endmodule

// File: rtl/phase_tune_seq.sv
module phase_tune_seq
    import phase_tune_pkg::*;
#(
    parameter int PHASES = 32,
    parameter int STEPS  = 40,
    parameter int TMO_W  = 32,
    parameter int MODE_W = 4,
    localparam int PH_W  = $clog2(PHASES),
    localparam int CNT_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] bus_mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [PHASES-1:0] mask_o,
    output logic              tmo_wr_o,
    output logic [TMO_W-1:0]  tmo_data_o,
    output logic              tim_req_o,
    output logic              tim_final_o,
    output logic [PH_W-1:0]   tim_phase_o,
    output logic [MODE_W-1:0] tim_mode_o,
    input  logic              tim_ack_i,
    output logic              cmd_req_o,
    input  logic              cmd_ack_i,
    input  logic              cmd_pass_i,
    output logic              fnd_req_o,
    input  logic              fnd_ack_i,
    input  logic              fnd_allfail_i,
    input  logic [PH_W-1:0]   fnd_phase_i
);
    tune_state_t       state_q, state_d;
    logic [CNT_W-1:0]  step;
    logic              step_last;
    logic [PH_W-1:0]   trial_phase;
    logic [PH_W-1:0]   best_q;
    logic              begin_sweep;
    logic              trial_done;

    assign begin_sweep = (state_q == ST_IDLE) && start_i;
    assign trial_done  = (state_q == ST_TUNE) && cmd_ack_i;
    assign trial_phase = PH_W'(step % CNT_W'(PHASES));

    phase_tune_step_ctr #(.STEPS(STEPS)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (begin_sweep),
        .inc  (trial_done && !step_last),
        .step (step),
        .last (step_last)
    );

    phase_tune_mask #(.PHASES(PHASES)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (begin_sweep),
        .wr_en (trial_done),
        .wr_idx(trial_phase),
        .wr_val(cmd_pass_i),
        .mask  (mask_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_TMO;
            ST_TMO:                  state_d = ST_SET;
            ST_SET:   if (tim_ack_i) state_d = ST_TUNE;
            ST_TUNE:  if (cmd_ack_i) state_d = step_last ? ST_FIND : ST_TMO;
            ST_FIND:  if (fnd_ack_i) state_d = fnd_allfail_i ? ST_IDLE : ST_APPLY;
            ST_APPLY: if (tim_ack_i) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            best_q  <= '0;
            err_o   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= 1'b0;
            if (begin_sweep)
                err_o <= 1'b0;
            if (state_q == ST_FIND && fnd_ack_i) begin
                best_q <= fnd_phase_i;
                if (fnd_allfail_i) begin
                    err_o  <= 1'b1;
                    done_o <= 1'b1;
                end
            end
            if (state_q == ST_APPLY && tim_ack_i)
                done_o <= 1'b1;
        end
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        tmo_wr_o    = (state_q == ST_TMO);
        tmo_data_o  = '1;
        tim_req_o   = (state_q == ST_SET) || (state_q == ST_APPLY);
        tim_final_o = (state_q == ST_APPLY);
        tim_phase_o = (state_q == ST_APPLY) ? best_q : trial_phase;
        tim_mode_o  = bus_mode_i;
        cmd_req_o   = (state_q == ST_TUNE);
        fnd_req_o   = (state_q == ST_FIND);
    end
endmodule

// File: rtl/phase_tune_seq_chk.sv
module phase_tune_seq_chk #(
    parameter int PHASES = 32,
    parameter int TMO_W  = 32,
    parameter int PH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              err_o,
    input logic [PHASES-1:0] mask_o,
    input logic              tmo_wr_o,
    input logic [TMO_W-1:0]  tmo_data_o,
    input logic              tim_req_o,
    input logic              tim_final_o,
    input logic [PH_W-1:0]   tim_phase_o,
    input logic              tim_ack_i,
    input logic              cmd_req_o,
    input logic              cmd_ack_i,
    input logic              fnd_req_o,
    input logic              fnd_ack_i
);
    p_tim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tim_req_o && !tim_ack_i |=> tim_req_o && $stable(tim_phase_o) && $stable(tim_final_o));
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o && !cmd_ack_i |=> cmd_req_o);
    p_fnd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fnd_req_o && !fnd_ack_i |=> fnd_req_o);
    p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmo_wr_o, tim_req_o, cmd_req_o, fnd_req_o}));
    p_tmo_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tim_req_o) && !tim_final_o |-> $past(tmo_wr_o));
    p_tmo_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_wr_o |-> (tmo_data_o == {TMO_W{1'b1}}));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mask_o == '0));
    p_no_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !busy_o |-> !tim_req_o);
endmodule

bind phase_tune_seq phase_tune_seq_chk #(
    .PHASES(PHASES), .TMO_W(TMO_W), .PH_W(PH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .err_o(err_o), .mask_o(mask_o),
    .tmo_wr_o(tmo_wr_o), .tmo_data_o(tmo_data_o), .tim_req_o(tim_req_o),
    .tim_final_o(tim_final_o), .tim_phase_o(tim_phase_o), .tim_ack_i(tim_ack_i),
    .cmd_req_o(cmd_req_o), .cmd_ack_i(cmd_ack_i), .fnd_req_o(fnd_req_o),
    .fnd_ack_i(fnd_ack_i)
);

// File: tb/sim_phase_tune_seq.sv
`timescale 1ns/1ps
module sim_phase_tune_seq;
    localparam int PHASES = 32, STEPS = 40, TMO_W = 32, MODE_W = 4, PH_W = 5;

    logic clk = 0, rst_n = 0, start_i = 0;
    logic [MODE_W-1:0] bus_mode_i = '0;
    logic busy_o, done_o, err_o, tmo_wr_o, tim_req_o, tim_final_o, cmd_req_o, fnd_req_o;
    logic [PHASES-1:0] mask_o;
    logic [TMO_W-1:0] tmo_data_o;
    logic [PH_W-1:0] tim_phase_o;
    logic [MODE_W-1:0] tim_mode_o;
    logic tim_ack_i = 0, cmd_ack_i = 0, cmd_pass_i = 0, fnd_ack_i = 0, fnd_allfail_i = 0;
    logic [PH_W-1:0] fnd_phase_i = '0;

    int checks = 0, errors = 0;
    int mode = 0, lat = 0;
    int ntim, ntmo, ncmd, nfinal, fin_phase, fin_mode;
    int tcnt = 0, ccnt = 0, fcnt = 0;
    logic prev_tim = 0, prev_busy = 0;
    logic [PHASES-1:0] exp_mask;

    always #10 clk = ~clk;

    phase_tune_seq u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit pat(input int m, input int trial);
        int ph = trial % PHASES;
        case (m)
            0: return 1'b0;
            1: return 1'b1;
            2: return (ph >= 5 && ph <= 12) && !(trial >= PHASES && (ph == 5 || ph == 6));
            3: return trial >= PHASES;
            default: return trial[0];
        endcase
    endfunction

    function automatic logic [PHASES-1:0] model_mask(input int m);
        logic [PHASES-1:0] r = '0;
        for (int t = 0; t < STEPS; t++) r[t % PHASES] = pat(m, t);
        return r;
    endfunction

    function automatic int pick(input logic [PHASES-1:0] m);
        return ($countones(m) * 7 + 3) % PHASES;
    endfunction

    // monitor and responders
    initial forever begin
        @(negedge clk);
        if (busy_o && !prev_busy)
            chk(mask_o == '0, "R5 mask clear at start", mask_o, 0);
        prev_busy = busy_o;
        if (tmo_wr_o) begin
            ntmo++;
            chk(tmo_data_o == '1, "R3 timeout data", tmo_data_o, 32'hFFFF_FFFF);
        end
        if (tim_req_o && !prev_tim) begin
            if (tim_final_o) begin
                nfinal++; fin_phase = tim_phase_o; fin_mode = tim_mode_o;
            end else begin
                chk(tim_phase_o == PH_W'(ntim % PHASES), "R2 trial phase", tim_phase_o, ntim % PHASES);
                chk(ntmo == ntim + 1, "R3 timeout before trial", ntmo, ntim + 1);
                ntim++;
            end
        end
        prev_tim = tim_req_o;
        if (tim_req_o && !tim_ack_i) begin
            if (tcnt >= lat) tim_ack_i = 1; else tcnt++;
        end else begin tim_ack_i = 0; tcnt = 0; end
        if (cmd_req_o && !cmd_ack_i) begin
            if (ccnt >= lat) begin cmd_ack_i = 1; cmd_pass_i = pat(mode, ncmd); ncmd++; end
            else ccnt++;
        end else begin cmd_ack_i = 0; ccnt = 0; cmd_pass_i = 0; end
        if (fnd_req_o && !fnd_ack_i) begin
            if (fcnt == 0)
                chk(mask_o == exp_mask, "R7 mask at finder", mask_o, exp_mask);
            if (fcnt >= lat) begin
                fnd_ack_i = 1; fnd_allfail_i = (exp_mask == '0);
                fnd_phase_i = PH_W'(pick(exp_mask));
            end else fcnt++;
        end else begin fnd_ack_i = 0; fcnt = 0; fnd_allfail_i = 0; end
    end

    task automatic run(input int m, input int l, input bit inject, input int md);
        mode = m; lat = l; bus_mode_i = MODE_W'(md);
        exp_mask = model_mask(m);
        ntim = 0; ntmo = 0; ncmd = 0; nfinal = 0; fin_phase = -1; fin_mode = -1;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        if (inject) begin
            repeat (30) @(negedge clk);
            start_i = 1; @(negedge clk); start_i = 0;
        end
        while (!done_o) @(negedge clk);
        chk(ntim == STEPS, inject ? "R10 trials with start mid-sweep" : "R2 trial count", ntim, STEPS);
        chk(ntmo == STEPS, inject ? "R10 timeout writes" : "R3 timeout writes", ntmo, STEPS);
        chk(mask_o == exp_mask, "R4 final mask", mask_o, exp_mask);
        if (exp_mask == '0) begin
            chk(err_o == 1, "R8 error flag", err_o, 1);
            chk(nfinal == 0, "R8 no final request", nfinal, 0);
        end else begin
            chk(err_o == 0, "R9 error flag", err_o, 0);
            chk(nfinal == 1, "R9 final request count", nfinal, 1);
            chk(fin_phase == pick(exp_mask), "R9 final phase", fin_phase, pick(exp_mask));
            chk(fin_mode == md, "R9 final mode", fin_mode, md);
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R8 done single pulse", {done_o, busy_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o, "R1 reset status", {busy_o, done_o, err_o}, 0);
        chk(!tmo_wr_o && !tim_req_o && !cmd_req_o && !fnd_req_o, "R1 reset requests",
            {tmo_wr_o, tim_req_o, cmd_req_o, fnd_req_o}, 0);
        chk(mask_o == '0, "R1 reset mask", mask_o, 0);
        rst_n = 1;
        @(negedge clk);
        run(1, 0, 0, 3);
        run(2, 2, 0, 5);
        run(0, 1, 0, 7);
        run(3, 0, 0, 2);
        run(4, 3, 0, 9);
        run(2, 1, 1, 6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule